// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the 32-bit interrupt control word that sits beside a set of DMA channels. Software uses it to choose which channel completions may interrupt, to turn on a global gate, and to see which channels have finished. Software can also force a bus-error request. Each channel reports completion with a one-cycle done pulse. The completion flag for that channel latches only when its enable is set. Software clears flags by writing ones to them. A write of zero leaves a flag as it is.

The block forms one master interrupt condition from the register contents. A sticky "sent" bit records that a request has already gone out. The condition is re-evaluated on every software write and on every hardware flag set. A single-cycle request toward the main interrupt status logic is raised only when the condition is true and the sent bit was clear before that event. After a write that leaves the condition false, the sent bit is clear, so the next rising condition raises a fresh request.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the read value is 0x00000000 and the interrupt pulse output is low.
- R2: A write loads bits 5..0, bit 15 (bus error), bits 22..16 (channel enables) and bit 23 (global enable) straight from the written word. Bits 14..6 always read as zero. Bit 31 (sent) cannot be written.
- R3: A write clears each flag bit 24+n whose written bit is one, and leaves each flag whose written bit is zero unchanged.
- R4: A done pulse on channel n sets flag bit 24+n only when enable bit 16+n is set in the register before that cycle. Otherwise the pulse has no effect.
- R5: A bus-error pulse sets bit 15.
- R6: The master condition is (bit 23 set and any of bits 30..24 set) or bit 15 set. It is judged on the updated value. An event is a write, a flag set or a bus-error pulse. When an event leaves the condition true and bit 31 was clear, bit 31 becomes set and the pulse output is high for one cycle, in the cycle after the event.
- R7: An event that finds bit 31 already set and leaves the condition true raises no pulse, and bit 31 stays set.
- R8: A write that leaves the condition false clears bit 31 and raises no pulse.
- R9: When a done pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends set.
- R10: The pulse output is never high for two cycles in a row. While bit 31 is set, the master condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe for the control word |
| wr_data | input | 32 | Word written by software |
| chan_done | input | 7 | Per-channel completion pulses |
| bus_err | input | 1 | Bus-error pulse |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle request toward the interrupt status register |

## Verification
Two things can happen in the same cycle: a software write that clears a channel flag, and a done pulse on that channel that sets it. The bench drives both in one clock with the channel enabled and the global gate on. It expects the flag to read back as set, and it expects a fresh pulse because the sent bit was clear. A second collision checks the sent bit. A software write that keeps the condition true arrives while the bit is already set, and the bench expects no second pulse.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
  localparam int NCH      = 7;
  localparam int LOW_W    = 6;
  localparam int BERR_BIT = 15;
  localparam int EN_LO    = 16;
  localparam int GEN_BIT  = EN_LO + NCH;
  localparam int FLAG_LO  = GEN_BIT + 1;
  localparam int SENT_BIT = FLAG_LO + NCH;
  localparam int WORD_W   = SENT_BIT + 1;

  localparam logic [WORD_W-1:0] WMASK =
      (WORD_W'(1) << GEN_BIT)
    | (((WORD_W'(1) << NCH) - WORD_W'(1)) << EN_LO)
    | (WORD_W'(1) << BERR_BIT)
    | ((WORD_W'(1) << LOW_W) - WORD_W'(1));
endpackage

// File: rtl/dicr_flag_bank.sv
module dicr_flag_bank #(
  parameter int NCH = 7
) (
  input  logic [NCH-1:0] flags_q,
  input  logic [NCH-1:0] en_q,
  input  logic           wr_en,
  input  logic [NCH-1:0] clr_bits,
  input  logic [NCH-1:0] done,
  output logic [NCH-1:0] flags_d,
  output logic           hw_set
);
  logic [NCH-1:0] set_v;

  // R3/R4/R9: per-channel clear-on-one, gated set, set dominates
  for (genvar n = 0; n < NCH; n++) begin : g_chan
    logic kept;
    always_comb begin
      set_v[n]   = done[n] & en_q[n];
      kept       = flags_q[n] & ~(wr_en & clr_bits[n]);
      flags_d[n] = kept | set_v[n];
    end
  end

  assign hw_set = |set_v;
endmodule

// File: rtl/dicr_master.sv
module dicr_master #(
  parameter int NCH = 7
) (
  input  logic           gen_d,
  input  logic           berr_d,
  input  logic [NCH-1:0] flags_d,
  input  logic           sent_q,
  input  logic           evt,
  output logic           sent_d,
  output logic           pulse_d
);
  logic cond;

  // R6: master condition on updated contents
  always_comb begin
    cond = (gen_d & (|flags_d)) | berr_d;
    if (evt) begin
      sent_d  = cond;                 // R6/R7/R8
      pulse_d = cond & ~sent_q;
    end else begin
      sent_d  = sent_q;
      pulse_d = 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dicr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [6:0]  chan_done,
  input  logic        bus_err,
  output logic [31:0] rd_data,
  output logic        irq_pulse
);
  // control fields
  logic [LOW_W-1:0] low_q,  low_d;
  logic             berr_q, berr_d;
  logic [NCH-1:0]   en_q,   en_d;
  logic             gen_q,  gen_d;
  logic [NCH-1:0]   flags_q, flags_d;
  logic             sent_q, sent_d;
  logic             irq_q,  irq_d;
  logic             hw_set;
  logic             evt;
  logic             ctl_ce;

  // reset release synchroniser (assert async, release sync)
  logic [1:0] rst_sync;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1] & rst_n;

  // R2: software-loaded fields, clock enable written out
  assign ctl_ce = wr_en;

  always_comb begin
    low_d  = low_q;
    en_d   = en_q;
    gen_d  = gen_q;
    berr_d = berr_q;
    if (ctl_ce) begin
      low_d  = wr_data[LOW_W-1:0];
      en_d   = wr_data[EN_LO +: NCH];
      gen_d  = wr_data[GEN_BIT];
      berr_d = wr_data[BERR_BIT];
    end
    berr_d = berr_d | bus_err;        // R5: hardware set
  end

  dicr_flag_bank #(.NCH(NCH)) u_flags (
    .flags_q  (flags_q),
    .en_q     (en_q),
    .wr_en    (wr_en),
    .clr_bits (wr_data[FLAG_LO +: NCH]),
    .done     (chan_done[NCH-1:0]),
    .flags_d  (flags_d),
    .hw_set   (hw_set)
  );

  assign evt = wr_en | hw_set | bus_err;

  dicr_master #(.NCH(NCH)) u_master (
    .gen_d   (gen_d),
    .berr_d  (berr_d),
    .flags_d (flags_d),
    .sent_q  (sent_q),
    .evt     (evt),
    .sent_d  (sent_d),
    .pulse_d (irq_d)
  );

  // R1: registers, reset to zero
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      low_q   <= '0;
      berr_q  <= 1'b0;
      en_q    <= '0;
      gen_q   <= 1'b0;
      flags_q <= '0;
      sent_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      low_q   <= low_d;
      berr_q  <= berr_d;
      en_q    <= en_d;
      gen_q   <= gen_d;
      flags_q <= flags_d;
      sent_q  <= sent_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    rd_data                   = '0;
    rd_data[LOW_W-1:0]        = low_q;
    rd_data[BERR_BIT]         = berr_q;
    rd_data[EN_LO +: NCH]     = en_q;
    rd_data[GEN_BIT]          = gen_q;
    rd_data[FLAG_LO +: NCH]   = flags_q;
    rd_data[SENT_BIT]         = sent_q;
  end

  assign irq_pulse = irq_q;
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [6:0]  chan_done,
  input logic [31:0] rd_data,
  input logic        irq_pulse
);
  a_r2_dead_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[14:6] == 9'd0);

  a_r6_pulse_sets_sent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> rd_data[31]);

  a_r7_pulse_needs_clear_sent: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(rd_data[31]));

  a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r10_sent_implies_cond: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] |-> ((rd_data[23] && (|rd_data[30:24])) || rd_data[15]));

  for (genvar n = 0; n < 7; n++) begin : g_flag
    a_r4_flag_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rd_data[24+n]) && rd_data[24+n]) |-> $past(chan_done[n] && rd_data[16+n]));
  end
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_done (chan_done),
  .rd_data   (rd_data),
  .irq_pulse (irq_pulse)
);

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [6:0]  chan_done;
  logic        bus_err;
  logic [31:0] rd_data;
  logic        irq_pulse;

  int checks;
  int errors;
  bit finished;

  logic [31:0] m_reg;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  dma_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .chan_done (chan_done),
    .bus_err   (bus_err),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // driver: apply one cycle of stimulus, push expected result
  task automatic step(input bit wr, input logic [31:0] wd,
                      input logic [6:0] dn, input bit be, input string tag);
    logic [31:0] nv;
    logic [6:0]  setv;
    bit          ev, cond, irq;
    @(negedge clk);
    wr_en = wr; wr_data = wd; chan_done = dn; bus_err = be;
    setv = dn & m_reg[22:16];
    nv = m_reg;
    if (wr) begin
      nv = wd & 32'h00FF803F;
      nv[30:24] = m_reg[30:24] & ~wd[30:24];
      nv[31] = m_reg[31];
    end
    nv[30:24] = nv[30:24] | setv;
    nv[15] = nv[15] | be;
    ev = wr || (setv != 0) || be;
    cond = (nv[23] && (nv[30:24] != 0)) || nv[15];
    irq = 1'b0;
    if (ev) begin
      irq = cond && !m_reg[31];
      nv[31] = cond;
    end
    m_reg = nv;
    exp_q.push_back({irq, nv});
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({irq_pulse, rd_data} !== e) begin
          errors++;
          $display("FAIL %s: got irq=%0b rd=%h expected irq=%0b rd=%h",
                   t, irq_pulse, rd_data, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    m_reg = '0;
    rst_n = 1'b0; wr_en = 0; wr_data = '0; chan_done = '0; bus_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_data !== 32'h0 || irq_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: got rd=%h irq=%0b expected rd=00000000 irq=0", rd_data, irq_pulse);
    end

    step(1, 32'hFFFF_FFFF, 7'h00, 0, "R2 masked write, R6 pulse via bus bit");
    step(0, 32'h0, 7'h00, 0, "R10 pulse lasts one cycle");
    step(1, 32'h0000_0000, 7'h00, 0, "R8 write drops condition, sent clears");
    step(1, 32'h8000_7FC0, 7'h00, 0, "R2 bit 31 and bits 14..6 not writable");
    step(1, 32'h007F_0000, 7'h00, 0, "R2 enables loaded");
    step(0, 32'h0, 7'h05, 0, "R4 enabled done sets flags, gate off");
    step(1, 32'h0001_0000, 7'h00, 0, "R3 zero write keeps flags");
    step(0, 32'h0, 7'h02, 0, "R4 disabled channel ignored");
    step(1, 32'h0081_0000, 7'h00, 0, "R6 gate on raises pulse");
    step(0, 32'h0, 7'h01, 0, "R7 flag set with sent already set");
    step(1, 32'h7F81_0000, 7'h00, 0, "R3 clear flags, R8 sent clears");
    step(1, 32'h0181_0000, 7'h01, 0, "R9 set beats clear, R6 fresh pulse");
    step(1, 32'h0081_8000, 7'h00, 0, "R7 write keeps condition, no pulse");
    step(1, 32'h7F00_0000, 7'h00, 0, "R8 all off");
    step(0, 32'h0, 7'h00, 1, "R5 bus error pulse sets bit 15 and pulses");
    step(0, 32'h0, 7'h00, 1, "R7 repeated bus error, no pulse");
    step(0, 32'h0, 7'h00, 0, "R10 idle");
    @(negedge clk);
    wr_en = 0; chan_done = '0; bus_err = 0;
    repeat (3) @(posedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule